// File: doc/BRIEF.md
# Shifting-Array Time-Difference Histogram Builder

This block builds a histogram of arrival-time differences for a buffer of pulse timestamps. It is a row of identical cells. Each cell stores one timestamp, loaded in ascending order, and owns the counter for one histogram bin. Timestamps are unsigned integers that are already scaled to bin-width units, so the bin of a difference is just its integer value.

Each pass moves a travelling copy of every timestamp one cell to the right. Each cell that still has a valid partner then subtracts the copy it received from its own timestamp. If the result lands inside the histogram, the cell asks the owning cell to count it. A round-robin arbiter applies these increments one per cycle, because a counter can take only one increment at a time. The next pass starts only after the arbiter has applied every request from the current pass.

The run stops at the first pass in which no active cell produces an in-range difference, or when no cell is active any more. The block then pulses `done_o`, and the counts can be read by index.

Top module: `tdoa_hist`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `pass_o` is 0 and every bin reads 0. Cell i takes the timestamp written with `load_idx_i = i` while the block is idle.
- R2: After a run, bin b (0..N-1) holds the number of pairs j<i with t_i - t_j = b.
- R3: A difference equal to N or larger produces no increment. A difference of exactly N-1 is counted in the last bin.
- R4: At pass k, only cells with index k or higher contribute. Cells below k sit out even when their stale partner value would fall in range.
- R5: `done_o` is high for exactly one cycle. At that point `pass_o` equals the first pass k (1..N-1) in which no active cell produced an in-range difference, or N if there was no such pass.
- R6: At most one bin counter increments per cycle. From the start edge to the done edge, the run takes exactly the sum over passes before the last of (2 + the number of in-range requests in that pass), plus 2 cycles.
- R7: Bin counters saturate at their maximum value of 2^CNT_W - 1 and never wrap.
- R8: A new shift pass never begins while increment requests from the previous pass are still pending.
- R9: `start_i` clears every bin before the new run, and `rd_cnt_o` shows the count of bin `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Write one timestamp (accepted only while idle) |
| load_idx_i | input | IDX_W | Target cell of the write |
| load_toa_i | input | TOA_W | Timestamp, in bin-width units |
| start_i | input | 1 | Begin a run (accepted only while idle) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when the run ends |
| pass_o | output | PASS_W | Current or final pass number |
| rd_idx_i | input | IDX_W | Bin to read |
| rd_cnt_o | output | CNT_W | Count of the selected bin |

## Verification
The bench goes after four corner cases, each with a distinct failure signature.

- **Last in-range difference.** It places a difference of exactly N-1 next to one of exactly N. An off-by-one range test would either drop the last bin or count an extra bin.
- **Inactive cells.** It uses small timestamps, so a cell that failed to sit out would subtract a zero copy and inflate low bins.
- **Saturation.** An all-equal buffer with narrow counters drives bin 0 past its maximum. A wrapping counter would read a small value.
- **Pass count and latency.** Exact pass numbers and cycle counts are checked. Early termination one pass off, skipped drains or parallel increments would all show up as a changed pass number or latency.

// File: rtl/tdoa_pkg.sv
package tdoa_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SHIFT = 2'd1,
    S_EVAL  = 2'd2,
    S_DRAIN = 2'd3
  } state_t;
endpackage

// File: rtl/tdoa_rr_arb.sv
module tdoa_rr_arb #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             adv_i,
  output logic             gnt_valid_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int c;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int off = 0; off < N; off++) begin
      c = int'(ptr_q) + off;
      if (c >= N) c = c - N;
      if (!gnt_valid_o && req_i[c]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i && gnt_valid_o) begin
      if (gnt_idx_o == IDX_W'(N - 1)) ptr_q <= '0;
      else ptr_q <= gnt_idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdoa_cell.sv
module tdoa_cell #(
  parameter int N      = 8,
  parameter int TOA_W  = 16,
  parameter int CNT_W  = 16,
  parameter int IDX    = 0,
  parameter int IDX_W  = $clog2(N),
  parameter int PASS_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TOA_W-1:0]  toa_i,
  input  logic              init_i,
  input  logic              shift_i,
  input  logic [TOA_W-1:0]  copy_in_i,
  input  logic [PASS_W-1:0] pass_i,
  input  logic              inc_i,
  output logic [TOA_W-1:0]  copy_o,
  output logic              req_o,
  output logic [IDX_W-1:0]  bin_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [PASS_W-1:0] MY_IDX  = PASS_W'(IDX);
  localparam logic [CNT_W-1:0]  CNT_MAX = '1;

  logic [TOA_W-1:0] toa_q, copy_q, diff;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toa_q  <= '0;
      copy_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load_i) toa_q <= toa_i;
      if (init_i) copy_q <= toa_q;
      else if (shift_i) copy_q <= copy_in_i;
      if (init_i) cnt_q <= '0;
      else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign diff   = toa_q - copy_q;
  assign req_o  = (MY_IDX >= pass_i) && (diff < TOA_W'(N));
  assign bin_o  = diff[IDX_W-1:0];
  assign copy_o = copy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tdoa_hist.sv
module tdoa_hist #(
  parameter int N_CELLS = 8,
  parameter int TOA_W   = 16,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(N_CELLS),
  localparam int PASS_W = $clog2(N_CELLS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [IDX_W-1:0]  load_idx_i,
  input  logic [TOA_W-1:0]  load_toa_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PASS_W-1:0] pass_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CNT_W-1:0]  rd_cnt_o
);
  import tdoa_pkg::*;

  state_t              state_q;
  logic [PASS_W-1:0]   pass_q;
  logic                done_q;
  logic [N_CELLS-1:0]  pend_q, req_w, inc_w;
  logic [IDX_W-1:0]    bin_q [N_CELLS];
  logic [IDX_W-1:0]    bin_w [N_CELLS];
  logic [TOA_W-1:0]    copy_w [N_CELLS];
  logic [CNT_W-1:0]    cnt_w [N_CELLS];
  logic [N_CELLS*CNT_W-1:0] cnt_flat;
  logic                idle, init_w, shift_w, drain_w, gnt_valid;
  logic [IDX_W-1:0]    gnt_idx;
  logic [N_CELLS-1:0]  pend_left;

  assign idle    = (state_q == S_IDLE);
  assign init_w  = idle && start_i;
  assign shift_w = (state_q == S_SHIFT);
  assign drain_w = (state_q == S_DRAIN);

  generate
    for (genvar j = 0; j < N_CELLS; j++) begin : g_cell
      logic [TOA_W-1:0] cin;
      if (j == 0) begin : g_head
        assign cin = '0;
      end else begin : g_link
        assign cin = copy_w[j-1];
      end
      assign inc_w[j] = drain_w && gnt_valid && (bin_q[gnt_idx] == IDX_W'(j));
      assign cnt_flat[j*CNT_W +: CNT_W] = cnt_w[j];

      tdoa_cell #(
        .N(N_CELLS), .TOA_W(TOA_W), .CNT_W(CNT_W), .IDX(j),
        .IDX_W(IDX_W), .PASS_W(PASS_W)
      ) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load_i && idle && (load_idx_i == IDX_W'(j))),
        .toa_i    (load_toa_i),
        .init_i   (init_w),
        .shift_i  (shift_w),
        .copy_in_i(cin),
        .pass_i   (pass_q),
        .inc_i    (inc_w[j]),
        .copy_o   (copy_w[j]),
        .req_o    (req_w[j]),
        .bin_o    (bin_w[j]),
        .cnt_o    (cnt_w[j])
      );
    end
  endgenerate

  tdoa_rr_arb #(.N(N_CELLS), .IDX_W(IDX_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (pend_q),
    .adv_i      (drain_w),
    .gnt_valid_o(gnt_valid),
    .gnt_idx_o  (gnt_idx)
  );

  always_comb begin
    pend_left = pend_q;
    pend_left[gnt_idx] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pass_q  <= '0;
      done_q  <= 1'b0;
      pend_q  <= '0;
      for (int j = 0; j < N_CELLS; j++) bin_q[j] <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          pass_q  <= '0;
          state_q <= S_SHIFT;
        end
        S_SHIFT: begin
          pass_q  <= pass_q + 1'b1;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          pend_q <= req_w;
          for (int j = 0; j < N_CELLS; j++) bin_q[j] <= bin_w[j];
          if (req_w == '0) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          pend_q <= pend_left;
          if (pend_left == '0) state_q <= S_SHIFT;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = !idle;
  assign done_o   = done_q;
  assign pass_o   = pass_q;
  assign rd_cnt_o = cnt_w[rd_idx_i];
endmodule

// File: rtl/tdoa_hist_chk.sv
module tdoa_hist_chk #(
  parameter int N      = 8,
  parameter int CNT_W  = 16,
  parameter int PASS_W = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input tdoa_pkg::state_t      state_i,
  input logic [N-1:0]          pend_i,
  input logic [N-1:0]          inc_i,
  input logic                  init_i,
  input logic [N*CNT_W-1:0]    cnt_i,
  input logic                  done_i,
  input logic [PASS_W-1:0]     pass_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_one_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc_i));

  p_drained_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == tdoa_pkg::S_SHIFT) |-> (pend_i == '0));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_pass_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i <= PASS_W'(N));

  generate
    for (genvar j = 0; j < N; j++) begin : g_sat
      p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_i[j*CNT_W +: CNT_W] == CNT_MAX && !init_i)
          |=> (cnt_i[j*CNT_W +: CNT_W] == CNT_MAX));
    end
  endgenerate
endmodule

bind tdoa_hist tdoa_hist_chk #(
  .N(N_CELLS), .CNT_W(CNT_W), .PASS_W(PASS_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_i(state_q),
  .pend_i (pend_q),
  .inc_i  (inc_w),
  .init_i (init_w),
  .cnt_i  (cnt_flat),
  .done_i (done_o),
  .pass_i (pass_o)
);

// File: tb/tdoa_hist_test.sv
module tdoa_hist_test;
  localparam int N      = 8;
  localparam int TOA_W  = 16;
  localparam int CNT_W  = 3;
  localparam int IDX_W  = $clog2(N);
  localparam int PASS_W = $clog2(N + 1);
  localparam int NVEC   = 5;
  localparam int CMAX   = (1 << CNT_W) - 1;

  localparam logic [TOA_W-1:0] VECS [NVEC][N] = '{
    '{16'd0, 16'd3, 16'd6, 16'd9, 16'd12, 16'd15, 16'd18, 16'd21},
    '{16'd0, 16'd7, 16'd15, 16'd30, 16'd45, 16'd60, 16'd75, 16'd90},
    '{16'd0, 16'd100, 16'd200, 16'd300, 16'd400, 16'd500, 16'd600, 16'd700},
    '{16'd0, 16'd1, 16'd2, 16'd4, 16'd7, 16'd8, 16'd9, 16'd15},
    '{16'd5, 16'd5, 16'd5, 16'd5, 16'd5, 16'd5, 16'd5, 16'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 1'b0, start = 1'b0;
  logic [IDX_W-1:0] load_idx = '0, rd_idx = '0;
  logic [TOA_W-1:0] load_toa = '0;
  logic busy, done;
  logic [PASS_W-1:0] pass;
  logic [CNT_W-1:0] rd_cnt;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tdoa_hist #(.N_CELLS(N), .TOA_W(TOA_W), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .load_idx_i(load_idx),
    .load_toa_i(load_toa), .start_i(start), .busy_o(busy), .done_o(done),
    .pass_o(pass), .rd_idx_i(rd_idx), .rd_cnt_o(rd_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int v, input string tag);
    int exp_bin [N];
    int exp_pass, exp_cyc, cyc, reqs;
    bit stop;
    for (int b = 0; b < N; b++) exp_bin[b] = 0;
    for (int i = 1; i < N; i++)
      for (int j = 0; j < i; j++) begin
        int d = int'(VECS[v][i]) - int'(VECS[v][j]);
        if (d >= 0 && d < N && exp_bin[d] < CMAX) exp_bin[d]++;
      end
    exp_pass = N; exp_cyc = 2; stop = 0;
    for (int k = 1; k <= N; k++) begin
      if (!stop) begin
        reqs = 0;
        for (int i = k; i < N; i++) begin
          int d = int'(VECS[v][i]) - int'(VECS[v][i-k]);
          if (d >= 0 && d < N) reqs++;
        end
        if (reqs == 0) begin exp_pass = k; stop = 1; end
        else exp_cyc += 2 + reqs;
      end
    end
    // R1: load one timestamp per cell
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      load = 1'b1; load_idx = IDX_W'(i); load_toa = VECS[v][i];
    end
    @(negedge clk); load = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk); cyc++; #1;
    end
    check("R6 run latency", cyc, exp_cyc);
    check("R5 final pass", int'(pass), exp_pass);
    @(posedge clk); #1;
    check("R5 done one cycle", int'(done), 0);
    for (int b = 0; b < N; b++) begin
      rd_idx = IDX_W'(b); #1;
      check(tag, int'(rd_cnt), exp_bin[b]);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 pass after reset", int'(pass), 0);
    for (int b = 0; b < N; b++) begin
      rd_idx = IDX_W'(b); #1;
      check("R1 bin after reset", int'(rd_cnt), 0);
    end
    for (int v = 0; v < NVEC; v++) begin
      string tag;
      case (v)
        0: tag = "R2 periodic bins";
        1: tag = "R3 range edge bins";
        2: tag = "R9 cleared bins";
        3: tag = "R4 inactive cells";
        default: tag = "R7 saturated bins";
      endcase
      run_vec(v, tag);
    end
    // R9: rerun of a populated buffer starts from zero counts
    run_vec(0, "R9 rerun bins");
    check("R1 idle after runs", int'(busy), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule